// File: doc/BRIEF.md
# Host/Slave Buffer Handshake Flags

This block is the attention-flag register that two bus agents, a host and a slave, use to pass a shared data buffer back and forth. It holds three flags. The event flag lets the slave raise an attention request toward the host. The slave-done flag says the slave has filled the buffer. The host-done flag says the host has filled the buffer. Each agent has its own synchronous register port with byte-wide write data and combinational read data. Both ports run on one clock.

The set and clear rights are asymmetric. The host writes a 1 to set host-done, and writes a 1 to clear event or slave-done. The slave may set event or slave-done, or clear host-done, only after it has read that flag in the opposite state. The slave's read arms a per-flag latch, and the slave's next write uses up every latch, whatever that write does. A level interrupt toward the host is raised, one cycle late, while the enable input is high and event or slave-done is set.

Top module: `hsflag_reg`

## Requirements
- R1: After reset all three flags read 0 and `hostIrq` is 0.
- R2: Bit 4 is the event flag, bit 3 is slave-done and bit 2 is host-done. Bits 7:5 and 1:0 read 0, and writes to them are ignored. Both read ports return the same byte.
- R3: A slave write with bit 4 = 1 sets the event flag only if the slave's most recent read showed bit 4 = 0 and no slave write has happened since that read.
- R4: A host write with bit 4 = 1 clears the event flag. A host write with bit 4 = 0 leaves it unchanged.
- R5: A slave write with bit 3 = 1 sets slave-done under the same armed-read rule as R3, applied to bit 3.
- R6: A host write with bit 3 = 1 clears slave-done. A host write with bit 3 = 0 leaves it unchanged.
- R7: A host write with bit 2 = 1 sets host-done. No slave write ever sets it.
- R8: A slave write with bit 2 = 0 clears host-done only if the slave's most recent read showed bit 2 = 1 and no slave write has happened since that read. A slave write with bit 2 = 1 leaves it unchanged.
- R9: Every slave write consumes all of the slave's arming, whether or not it changes a flag. An unarmed slave write leaves the flags unchanged.
- R10: When a flag is set and cleared in the same cycle, it ends up 0.
- R11: `hostIrq` is a registered copy of `irqEn AND (event OR slave-done)`, one cycle behind the flags and the enable.
- R12: When the slave reads and writes in the same cycle, the write uses the arming from earlier reads, and that read arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (current flags) |
| slvRd | input | 1 | Slave read strobe (arms flags) |
| slvWr | input | 1 | Slave write strobe |
| slvWdata | input | 8 | Slave write byte |
| slvRdata | output | 8 | Slave read byte (current flags) |
| irqEn | input | 1 | Host interrupt enable |
| hostIrq | output | 1 | Registered level interrupt to the host |

## Verification
The flags are driven with several kinds of slave write:
- writes preceded by a read that saw the opposite state;
- writes with no read before them;
- writes after an earlier write has already used up the arming;
- writes issued in the same cycle as a read.

Together these separate a design that gates on the arming latch from one that only looks at the data bit. Host writes of all-ones, of zero and of single bits show which bits each agent may touch, and that the pad bits stay at 0. A host clear that collides with an armed slave set checks the priority between the two. Toggling the enable, and sampling the interrupt both in the cycle right after a flag change and one cycle later, pins down the interrupt's one-cycle lag.

// File: rtl/hsflag_pkg.sv
package hsflag_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int IDX_EVT = 0;
  localparam int IDX_SDN = 1;
  localparam int IDX_HDN = 2;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setStb;
    logic [NUM_FLAGS-1:0] clrStb;
  } flagStb_t;
endpackage

// File: rtl/hsflag_ctl.sv
module hsflag_ctl
  import hsflag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EVT_BIT = 4,
  parameter int SDN_BIT = 3,
  parameter int HDN_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic                 slvRd,
  input  logic                 slvWr,
  input  logic [DATA_W-1:0]    slvWdata,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  output flagStb_t             stb
);
  // flag index -> bit position in the byte
  localparam int BIT_POS [NUM_FLAGS] = '{EVT_BIT, SDN_BIT, HDN_BIT};
  // the level a slave read must see to arm each flag
  localparam logic [NUM_FLAGS-1:0] ARM_LEVEL = 3'b100;
  // flags that the host sets and the slave clears
  localparam logic [NUM_FLAGS-1:0] HOST_SETS = 3'b100;

  logic [NUM_FLAGS-1:0] slvArm;
  logic [NUM_FLAGS-1:0] slvArmNext;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    // a write consumes the arming; a read alone re-evaluates it
    always_comb begin
      if (slvWr)      slvArmNext[g] = 1'b0;
      else if (slvRd) slvArmNext[g] = (flagsIn[g] == ARM_LEVEL[g]);
      else            slvArmNext[g] = slvArm[g];
    end

    if (HOST_SETS[g]) begin : g_hostSet
      assign stb.setStb[g] = hostWr & hostWdata[BIT_POS[g]];
      assign stb.clrStb[g] = slvWr & ~slvWdata[BIT_POS[g]] & slvArm[g];
    end else begin : g_slvSet
      assign stb.setStb[g] = slvWr & slvWdata[BIT_POS[g]] & slvArm[g];
      assign stb.clrStb[g] = hostWr & hostWdata[BIT_POS[g]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) slvArm <= '0;
    else       slvArm <= slvArmNext;
  end

  // the remaining data bits carry nothing
  logic unusedDataBits;
  assign unusedDataBits = ^{hostWdata, slvWdata};

  // R9: an unarmed slave write never sets the event flag
  p_unarmed_noset_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (slvWr && !slvArm[IDX_EVT] && !flagsIn[IDX_EVT]) |=> !flagsIn[IDX_EVT]);

  // R12: a write issued together with a read leaves nothing armed
  p_write_disarms_r12 : assert property (@(posedge clk) disable iff (!rstN)
    (slvWr && slvRd) |=> (slvArm == '0));
endmodule

// File: rtl/hsflag_dp.sv
module hsflag_dp
  import hsflag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EVT_BIT = 4,
  parameter int SDN_BIT = 3,
  parameter int HDN_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStb_t             stb,
  input  logic                 irqEn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]    rdata,
  output logic                 hostIrq
);
  localparam int BIT_POS [NUM_FLAGS] = '{EVT_BIT, SDN_BIT, HDN_BIT};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                flags[g] <= 1'b0;
      else if (stb.clrStb[g])   flags[g] <= 1'b0;   // clear has priority
      else if (stb.setStb[g])   flags[g] <= 1'b1;
    end

    // R10: a colliding set and clear leaves the flag low
    p_clear_wins_r10 : assert property (@(posedge clk) disable iff (!rstN)
      (stb.setStb[g] && stb.clrStb[g]) |=> !flags[g]);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_FLAGS; i++) rdata[BIT_POS[i]] = flags[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= irqEn & (flags[IDX_EVT] | flags[IDX_SDN]);
  end
endmodule

// File: rtl/hsflag_reg.sv
module hsflag_reg
  import hsflag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EVT_BIT = 4,
  parameter int SDN_BIT = 3,
  parameter int HDN_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              slvRd,
  input  logic              slvWr,
  input  logic [DATA_W-1:0] slvWdata,
  output logic [DATA_W-1:0] slvRdata,
  input  logic              irqEn,
  output logic              hostIrq
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << EVT_BIT) | (1 << SDN_BIT) | (1 << HDN_BIT));

  flagStb_t             stb;
  logic [NUM_FLAGS-1:0] flags;
  logic [DATA_W-1:0]    rdata;

  hsflag_ctl #(.DATA_W(DATA_W), .EVT_BIT(EVT_BIT), .SDN_BIT(SDN_BIT), .HDN_BIT(HDN_BIT)) u_ctl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostWdata(hostWdata),
    .slvRd(slvRd), .slvWr(slvWr), .slvWdata(slvWdata),
    .flagsIn(flags), .stb(stb)
  );

  hsflag_dp #(.DATA_W(DATA_W), .EVT_BIT(EVT_BIT), .SDN_BIT(SDN_BIT), .HDN_BIT(HDN_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .irqEn(irqEn),
    .flags(flags), .rdata(rdata), .hostIrq(hostIrq)
  );

  assign hostRdata = rdata;
  assign slvRdata  = rdata;

  // R2: pad bits always read zero
  p_pad_zero_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (hostRdata & ~USED_MASK) == '0);

  // R4: a host 1 on the event bit clears it
  p_host_clr_evt_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostWdata[EVT_BIT]) |=> !hostRdata[EVT_BIT]);

  // R6: a host 1 on the slave-done bit clears it
  p_host_clr_sdn_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostWdata[SDN_BIT]) |=> !hostRdata[SDN_BIT]);

  // R7: a host 1 on the host-done bit sets it when no slave write collides
  p_host_set_hdn_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostWdata[HDN_BIT] && !slvWr) |=> hostRdata[HDN_BIT]);

  // R11: the interrupt is masked by the enable one cycle later
  p_irq_masked_r11 : assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |=> !hostIrq);

  // R11: a pending enabled source raises the interrupt one cycle later
  p_irq_follows_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && (hostRdata[EVT_BIT] || hostRdata[SDN_BIT])) |=> hostIrq);
endmodule

// File: tb/sim_hsflag_reg.sv
`timescale 1ns/1ps
module sim_hsflag_reg;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hostWr, slvRd, slvWr, irqEn;
  logic [7:0] hostWdata, slvWdata, hostRdata, slvRdata;
  logic       hostIrq;

  always #2 clk = ~clk;   // 250 MHz

  hsflag_reg u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .slvRd(slvRd), .slvWr(slvWr), .slvWdata(slvWdata), .slvRdata(slvRdata),
    .irqEn(irqEn), .hostIrq(hostIrq)
  );

  typedef struct {
    string      tag;
    logic [7:0] expR;
    logic       expIrq;
  } item_t;

  item_t q[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 1'b0;

  // reference model, built from the requirements
  logic mEvt = 0, mSdn = 0, mHdn = 0, mIrq = 0;
  logic aEvt = 0, aSdn = 0, aHdn = 0;

  task automatic cyc(input logic hw, input logic [7:0] hd,
                     input logic sr, input logic sw, input logic [7:0] sd);
    logic sE, cE, sS, cS, sH, cH;
    hostWr = hw; hostWdata = hd; slvRd = sr; slvWr = sw; slvWdata = sd;
    @(posedge clk);
    sE = sw && sd[4] && aEvt;  cE = hw && hd[4];
    sS = sw && sd[3] && aSdn;  cS = hw && hd[3];
    sH = hw && hd[2];          cH = sw && !sd[2] && aHdn;
    mIrq = irqEn && (mEvt || mSdn);
    if (sw) begin aEvt = 0; aSdn = 0; aHdn = 0; end
    else if (sr) begin aEvt = !mEvt; aSdn = !mSdn; aHdn = mHdn; end
    mEvt = cE ? 1'b0 : (sE ? 1'b1 : mEvt);
    mSdn = cS ? 1'b0 : (sS ? 1'b1 : mSdn);
    mHdn = cH ? 1'b0 : (sH ? 1'b1 : mHdn);
    #1;
    hostWr = 0; slvRd = 0; slvWr = 0; hostWdata = '0; slvWdata = '0;
  endtask

  task automatic hostW(input logic [7:0] d); cyc(1, d, 0, 0, 8'h00); endtask
  task automatic slvR();                     cyc(0, 8'h00, 1, 0, 8'h00); endtask
  task automatic slvW(input logic [7:0] d);  cyc(0, 8'h00, 0, 1, d); endtask
  task automatic idle();                     cyc(0, 8'h00, 0, 0, 8'h00); endtask

  task automatic expectNow(input string tag);
    item_t it;
    it.tag = tag;
    it.expR = {3'b000, mEvt, mSdn, mHdn, 2'b00};
    it.expIrq = mIrq;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        nRun++;
        if (hostRdata !== it.expR || slvRdata !== it.expR || hostIrq !== it.expIrq) begin
          nFail++;
          $display("FAIL %s: actual host=%02h slave=%02h irq=%0b expected data=%02h irq=%0b",
                   it.tag, hostRdata, slvRdata, hostIrq, it.expR, it.expIrq);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; irqEn = 0;
    hostWr = 0; slvRd = 0; slvWr = 0; hostWdata = '0; slvWdata = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expectNow("R1 reset state");

    hostW(8'hFF);   expectNow("R2 R7 host all-ones sets only host-done");
    slvW(8'h10);    expectNow("R9 unarmed slave write ignored");

    irqEn = 1;
    slvR();         expectNow("R2 slave read leaves flags");
    slvW(8'h18);    expectNow("R3 R5 R8 armed slave write; R11 irq not yet");
    idle();         expectNow("R11 irq rises one cycle later");
    hostW(8'h00);   expectNow("R4 R6 host zero write ignored");
    hostW(8'h10);   expectNow("R4 host clears event");
    hostW(8'h08);   expectNow("R6 host clears slave-done; irq lags");
    idle();         expectNow("R11 irq falls one cycle later");

    hostW(8'h04);
    slvR();
    slvW(8'h04);    expectNow("R8 slave 1 on bit 2 keeps host-done");
    slvW(8'h10);    expectNow("R9 arming consumed by previous write");

    slvR();
    cyc(0, 8'h00, 1, 1, 8'h18); expectNow("R12 same-cycle read+write uses prior arming");
    hostW(8'h1C);   expectNow("R4 R6 R7 host clears and sets together");
    cyc(0, 8'h00, 1, 1, 8'h10); expectNow("R12 unarmed read+write ignored");
    slvW(8'h10);    expectNow("R12 read in write cycle did not arm");

    slvR();
    cyc(1, 8'h10, 0, 1, 8'h14); expectNow("R10 clear wins over set");

    slvR();
    slvW(8'h00);    expectNow("R8 armed slave zero clears host-done");
    slvW(8'h04);    expectNow("R7 slave cannot set host-done");

    slvR();
    slvW(8'h08);
    irqEn = 0;
    idle();         expectNow("R11 irq masked by enable");
    irqEn = 1;
    idle();         expectNow("R11 irq returns with enable");

    slvR();         // slave-done reads 1: no arming for it
    slvW(8'h08);
    hostW(8'h08);
    slvW(8'h08);    expectNow("R5 read showing 1 does not arm set");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule